// File: doc/BRIEF.md
# Fetch Priority Controller with Transition Watermark

This block decides whether each memory read issued by a display plane's fetch engine goes out at high or low priority. The decision follows how many blocks the plane's data buffer currently holds. Two thresholds set it. The lower one is the level-0 watermark, which another block supplies. The upper one is a transition level that this block derives. It starts from the level-0 watermark and adds a fixed minimum, a tunable amount and rules that depend on the tiling mode.

Between the two thresholds the block holds its last decision. A buffer that is refilling keeps fetching at high priority until it passes the transition level. It then fetches at low priority, so that other memory clients get bandwidth, until it drains below the level-0 watermark. The mechanism is armed only while the pipe is active and the idle power-saving enable is set. When it is not armed, every request is high priority and no transition level is reported.

Configuration inputs are captured in registers on each clock. The transition level is computed combinationally from those registers. The priority state is a single register that advances once per clock from the live fill level.

Top module: `fetch_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `req_high_prio` is 1, `trans_valid` is 0 and `trans_level` is 0.
- R2: When the registered `pipe_active` or the registered `idle_save_en` is 0, `trans_valid` is 0, `trans_level` is 0 and `req_high_prio` is 1, whatever the fill level.
- R3: With `y_tiled`=0 and the mechanism armed, `trans_level` equals the level-0 blocks plus 4, plus `trans_amount`, plus 1. When `wa_extra_blk`=1 it is one more than that.
- R4: With `y_tiled`=1, `trans_level` equals max(level-0 blocks, ceil(2 × Y-tile minimum)) + 4 + `trans_amount` + 1. `ytile_min` carries 2 fraction bits, so ceil(2 × value) equals ceil(raw/2). `wa_extra_blk` has no effect in this mode.
- R5: Whenever the sum in R3 or R4 exceeds 2047, `trans_level` reads 2047 and does not wrap.
- R6: While armed in the high state, a clock edge at which `fill_level` > `trans_level` makes `req_high_prio` 0 after that edge. A fill exactly equal to `trans_level` does not demote.
- R7: While armed in the low state, a clock edge at which `fill_level` < level-0 blocks makes `req_high_prio` 1 after that edge. A fill exactly equal to the level-0 blocks does not promote.
- R8: While armed, a fill level between the two thresholds (inclusive) leaves `req_high_prio` unchanged.
- R9: Configuration inputs take effect only at a clock edge. A change made between edges does not alter `trans_level` or `trans_valid` until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_active | input | 1 | Display pipe is running |
| idle_save_en | input | 1 | Idle power-saving feature enabled |
| y_tiled | input | 1 | Plane uses Y tiling |
| wa_extra_blk | input | 1 | Workaround: one extra block for non-Y-tiled planes |
| lvl0_blocks | input | 11 | Level-0 watermark in blocks |
| ytile_min | input | 13 | Y-tile minimum, unsigned with 2 fraction bits |
| trans_amount | input | 6 | Tunable transition amount in blocks (nominal 10) |
| fill_level | input | 11 | Current buffer fill in blocks |
| req_high_prio | output | 1 | 1 = issue reads at high priority |
| trans_level | output | 11 | Computed transition level in blocks, 0 when not armed |
| trans_valid | output | 1 | Transition mechanism armed |

## Verification
The hardest case to reach from the ports is an exact boundary crossing. The fill must sit one block either side of each threshold, while the block is already in the state that the crossing would leave. The bench therefore sets up a known configuration and ramps the fill level one block at a time up through the transition level and back down through the level-0 watermark. It then oscillates inside the band, so that each strict comparison is met in both directions from each state. The saturation corner needs large level-0 and Y-tile values together with the largest amount. A near-exhaustive sweep of the level-0 watermark, taken in steps across its full range and combined with every tiling and workaround setting, drives the sum past 2047.

// File: rtl/fprio_pkg.sv
package fprio_pkg;

  typedef enum logic {
    PRIO_LOW  = 1'b0,
    PRIO_HIGH = 1'b1
  } prio_e;

endpackage

// File: rtl/fprio_cfg_reg.sv
module fprio_cfg_reg #(
  parameter int BLK_W = 11,
  parameter int YT_W  = 13,
  parameter int AMT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_active,
  input  logic             idle_save_en,
  input  logic             y_tiled,
  input  logic             wa_extra_blk,
  input  logic [BLK_W-1:0] lvl0_blocks,
  input  logic [YT_W-1:0]  ytile_min,
  input  logic [AMT_W-1:0] trans_amount,
  output logic             pipe_q,
  output logic             save_q,
  output logic             ytiled_q,
  output logic             wa_q,
  output logic [BLK_W-1:0] lvl0_q,
  output logic [YT_W-1:0]  ytmin_q,
  output logic [AMT_W-1:0] amt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q   <= 1'b0;
      save_q   <= 1'b0;
      ytiled_q <= 1'b0;
      wa_q     <= 1'b0;
      lvl0_q   <= '0;
      ytmin_q  <= '0;
      amt_q    <= '0;
    end else begin
      pipe_q   <= pipe_active;
      save_q   <= idle_save_en;
      ytiled_q <= y_tiled;
      wa_q     <= wa_extra_blk;
      lvl0_q   <= lvl0_blocks;
      ytmin_q  <= ytile_min;
      amt_q    <= trans_amount;
    end
  end

endmodule

// File: rtl/fprio_trans_calc.sv
module fprio_trans_calc #(
  parameter int BLK_W      = 11,
  parameter int YT_FRAC    = 2,
  parameter int AMT_W      = 6,
  parameter int MIN_BLOCKS = 4
) (
  input  logic                     y_tiled,
  input  logic                     wa_extra_blk,
  input  logic [BLK_W-1:0]         lvl0_blocks,
  input  logic [BLK_W+YT_FRAC-1:0] ytile_min,
  input  logic [AMT_W-1:0]         trans_amount,
  output logic [BLK_W-1:0]         level
);

  localparam int YT_W  = BLK_W + YT_FRAC;
  localparam int SUM_W = BLK_W + 4;
  localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << BLK_W) - 1);
  localparam logic [SUM_W-1:0] ROUND_ADD = SUM_W'((1 << YT_FRAC) - 1);

  // ceil(2 * fixed-point value), kept wide
  function automatic logic [SUM_W-1:0] ceil_double(input logic [YT_W-1:0] raw);
    logic [SUM_W-1:0] w;
    w = SUM_W'(raw) << 1;
    w = w + ROUND_ADD;
    return w >> YT_FRAC;
  endfunction

  function automatic logic [SUM_W-1:0] pick_base(input logic ytl,
                                                 input logic [BLK_W-1:0] l0,
                                                 input logic [YT_W-1:0] ytm);
    logic [SUM_W-1:0] l0w;
    logic [SUM_W-1:0] ytw;
    l0w = SUM_W'(l0);
    ytw = ceil_double(ytm);
    if (ytl && (ytw > l0w)) return ytw;
    return l0w;
  endfunction

  function automatic logic [SUM_W-1:0] add_offset(input logic [SUM_W-1:0] base,
                                                  input logic [AMT_W-1:0] amt,
                                                  input logic extra);
    return base + SUM_W'(MIN_BLOCKS) + SUM_W'(amt) + SUM_W'(1) + SUM_W'(extra);
  endfunction

  function automatic logic [BLK_W-1:0] clamp(input logic [SUM_W-1:0] v);
    if (v > SAT_MAX) return BLK_W'(SAT_MAX);
    return BLK_W'(v);
  endfunction

  logic [SUM_W-1:0] base_w;
  logic [SUM_W-1:0] raw_sum;
  logic             extra_blk;

  always_comb begin
    extra_blk = wa_extra_blk & ~y_tiled;
    base_w    = pick_base(y_tiled, lvl0_blocks, ytile_min);
    raw_sum   = add_offset(base_w, trans_amount, extra_blk);
    level     = clamp(raw_sum);
  end

endmodule

// File: rtl/fprio_hyst.sv
module fprio_hyst
  import fprio_pkg::*;
#(
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mech_on,
  input  logic [BLK_W-1:0] fill_level,
  input  logic [BLK_W-1:0] upper_lvl,
  input  logic [BLK_W-1:0] lower_lvl,
  output logic             demote_evt,
  output logic             promote_evt,
  output logic             req_high
);

  prio_e state_q;
  prio_e state_d;

  always_comb begin
    demote_evt  = mech_on && (state_q == PRIO_HIGH) && (fill_level > upper_lvl);
    promote_evt = mech_on && (state_q == PRIO_LOW)  && (fill_level < lower_lvl);
    if (!mech_on)         state_d = PRIO_HIGH;
    else if (demote_evt)  state_d = PRIO_LOW;
    else if (promote_evt) state_d = PRIO_HIGH;
    else                  state_d = state_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PRIO_HIGH;
    else        state_q <= state_d;
  end

  assign req_high = (state_q == PRIO_HIGH) || !mech_on;

endmodule

// File: rtl/fetch_prio_ctrl.sv
module fetch_prio_ctrl #(
  parameter int BLK_W      = 11,
  parameter int YT_FRAC    = 2,
  parameter int AMT_W      = 6,
  parameter int MIN_BLOCKS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_active,
  input  logic                     idle_save_en,
  input  logic                     y_tiled,
  input  logic                     wa_extra_blk,
  input  logic [BLK_W-1:0]         lvl0_blocks,
  input  logic [BLK_W+YT_FRAC-1:0] ytile_min,
  input  logic [AMT_W-1:0]         trans_amount,
  input  logic [BLK_W-1:0]         fill_level,
  output logic                     req_high_prio,
  output logic [BLK_W-1:0]         trans_level,
  output logic                     trans_valid
);

  localparam int YT_W = BLK_W + YT_FRAC;

  logic             pipe_q;
  logic             save_q;
  logic             ytiled_q;
  logic             wa_q;
  logic [BLK_W-1:0] lvl0_q;
  logic [YT_W-1:0]  ytmin_q;
  logic [AMT_W-1:0] amt_q;
  logic             mech_on;
  logic [BLK_W-1:0] calc_level;
  logic             demote_evt;
  logic             promote_evt;

  fprio_cfg_reg #(.BLK_W(BLK_W), .YT_W(YT_W), .AMT_W(AMT_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .pipe_active  (pipe_active),
    .idle_save_en (idle_save_en),
    .y_tiled      (y_tiled),
    .wa_extra_blk (wa_extra_blk),
    .lvl0_blocks  (lvl0_blocks),
    .ytile_min    (ytile_min),
    .trans_amount (trans_amount),
    .pipe_q       (pipe_q),
    .save_q       (save_q),
    .ytiled_q     (ytiled_q),
    .wa_q         (wa_q),
    .lvl0_q       (lvl0_q),
    .ytmin_q      (ytmin_q),
    .amt_q        (amt_q)
  );

  assign mech_on = pipe_q & save_q;

  fprio_trans_calc #(
    .BLK_W(BLK_W), .YT_FRAC(YT_FRAC), .AMT_W(AMT_W), .MIN_BLOCKS(MIN_BLOCKS)
  ) u_calc (
    .y_tiled      (ytiled_q),
    .wa_extra_blk (wa_q),
    .lvl0_blocks  (lvl0_q),
    .ytile_min    (ytmin_q),
    .trans_amount (amt_q),
    .level        (calc_level)
  );

  assign trans_level = mech_on ? calc_level : '0;
  assign trans_valid = mech_on;

  fprio_hyst #(.BLK_W(BLK_W)) u_hyst (
    .clk         (clk),
    .rst_n       (rst_n),
    .mech_on     (mech_on),
    .fill_level  (fill_level),
    .upper_lvl   (trans_level),
    .lower_lvl   (lvl0_q),
    .demote_evt  (demote_evt),
    .promote_evt (promote_evt),
    .req_high    (req_high_prio)
  );

endmodule

// File: rtl/fprio_chk.sv
module fprio_chk #(
  parameter int BLK_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_active,
  input logic             idle_save_en,
  input logic [BLK_W-1:0] fill_level,
  input logic [BLK_W-1:0] lvl0_q,
  input logic [BLK_W-1:0] trans_level,
  input logic             trans_valid,
  input logic             req_high_prio,
  input logic             demote_evt,
  input logic             promote_evt
);

  // R2: not armed means every request is high priority
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trans_valid |-> req_high_prio);

  // R2: not armed means no transition level
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trans_valid |-> (trans_level == '0));

  // R3: the upper threshold lies above level-0 unless saturated (R5)
  assert_level_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trans_valid |-> ((trans_level > lvl0_q) || (trans_level == '1)));

  // R6: a demote event yields low priority after the edge
  assert_demote_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    demote_evt |=> (!req_high_prio || !trans_valid));

  // R6: priority only drops after the fill exceeded the transition level
  assert_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_high_prio) |-> ($past(fill_level) > $past(trans_level)));

  // R7: priority only rises by disarming or by the fill dropping below level-0
  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_high_prio) |-> (!trans_valid || ($past(fill_level) < $past(lvl0_q))));

  // R7: a promote event yields high priority after the edge
  assert_promote_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    promote_evt |=> req_high_prio);

  // R8: a fill inside the band holds the decision
  assert_band_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_valid && $past(trans_valid) && ($past(fill_level) >= $past(lvl0_q))
      && ($past(fill_level) <= $past(trans_level)))
    |-> (req_high_prio == $past(req_high_prio)));

  // R9: arming follows the enables sampled at the previous edge
  assert_arm_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (trans_valid == $past(pipe_active && idle_save_en)));

endmodule

bind fetch_prio_ctrl fprio_chk #(.BLK_W(BLK_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pipe_active   (pipe_active),
  .idle_save_en  (idle_save_en),
  .fill_level    (fill_level),
  .lvl0_q        (lvl0_q),
  .trans_level   (trans_level),
  .trans_valid   (trans_valid),
  .req_high_prio (req_high_prio),
  .demote_evt    (demote_evt),
  .promote_evt   (promote_evt)
);

// File: tb/sim_fetch_prio_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_prio_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MAXLVL = 2047;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_active = 1'b0;
  logic        idle_save_en = 1'b0;
  logic        y_tiled = 1'b0;
  logic        wa_extra_blk = 1'b0;
  logic [10:0] lvl0_blocks = '0;
  logic [12:0] ytile_min = '0;
  logic [5:0]  trans_amount = '0;
  logic [10:0] fill_level = '0;
  logic        req_high_prio;
  logic [10:0] trans_level;
  logic        trans_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side cycle model
  bit m_on = 0;
  bit m_state = 1;
  int m_l0 = 0;
  int m_trans = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pipe_active(pipe_active), .idle_save_en(idle_save_en),
    .y_tiled(y_tiled), .wa_extra_blk(wa_extra_blk), .lvl0_blocks(lvl0_blocks),
    .ytile_min(ytile_min), .trans_amount(trans_amount), .fill_level(fill_level),
    .req_high_prio(req_high_prio), .trans_level(trans_level), .trans_valid(trans_valid)
  );

  function automatic int exp_level(bit ytl, bit wa, int l0, int ytraw, int amt);
    int half_up;
    int base;
    int v;
    half_up = (ytraw + 1) / 2;
    base = l0;
    if (ytl && half_up > l0) base = half_up;
    v = base + 4 + amt + 1;
    if (!ytl && wa) v = v + 1;
    if (v > MAXLVL) v = MAXLVL;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the following negedge
  task automatic tick(bit chk, string tag);
    bit prev;
    string t;
    string tl;
    @(posedge clk);
    prev = m_state;
    if (!rst_n) begin
      m_state = 1; m_on = 0; m_l0 = 0; m_trans = 0;
    end else begin
      if (!m_on) m_state = 1;
      else if (m_state && int'(fill_level) > m_trans) m_state = 0;
      else if (!m_state && int'(fill_level) < m_l0) m_state = 1;
      m_on = pipe_active && idle_save_en;
      m_l0 = int'(lvl0_blocks);
      m_trans = m_on ? exp_level(y_tiled, wa_extra_blk, int'(lvl0_blocks),
                                 int'(ytile_min), int'(trans_amount)) : 0;
    end
    @(negedge clk);
    if (chk) begin
      t = tag; tl = tag;
      if (tag == "HYS") begin
        tl = "R8";
        if (prev && !m_state) t = "R6";
        else if (!prev && m_state) t = "R7";
        else t = "R8";
      end
      check(t, int'(req_high_prio), int'(m_state || !m_on));
      check(tl, int'(trans_level), m_trans);
      check(tl, int'(trans_valid), int'(m_on));
    end
  endtask

  task automatic set_cfg(bit pa, bit se, bit ytl, bit wa, int l0, int yt, int amt);
    pipe_active = pa; idle_save_en = se; y_tiled = ytl; wa_extra_blk = wa;
    lvl0_blocks = 11'(l0); ytile_min = 13'(yt); trans_amount = 6'(amt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int amts[3];
    int yts[4];
    amts[0] = 0; amts[1] = 10; amts[2] = 63;
    yts[0] = 0; yts[1] = 5; yts[2] = 1500; yts[3] = 8191;

    // R1: reset state with inputs that would otherwise arm the block
    @(negedge clk);
    set_cfg(1, 1, 0, 0, 100, 0, 10);
    fill_level = 11'd2000;
    tick(1, "R1");
    tick(1, "R1");
    rst_n = 1'b1;
    fill_level = '0;
    tick(0, "R1");
    check("R1", int'(trans_valid), 1);

    // R3, R4, R5: near-exhaustive sweep of the transition level
    for (int i = 0; i <= 66; i++) begin
      for (int a = 0; a < 3; a++) begin
        for (int y = 0; y < 2; y++) begin
          for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 4; k++) begin
              int l0v;
              int ev;
              string tg;
              l0v = (i == 66) ? 2047 : i * 31;
              set_cfg(1, 1, y[0], w[0], l0v, yts[k], amts[a]);
              ev = exp_level(y[0], w[0], l0v, yts[k], amts[a]);
              tg = (ev == MAXLVL) ? "R5" : (y != 0 ? "R4" : "R3");
              tick(1, tg);
            end
          end
        end
      end
    end

    // R9: a change between edges is not seen before the next edge
    set_cfg(1, 1, 0, 0, 100, 0, 10);
    tick(1, "R3");
    set_cfg(1, 1, 0, 1, 700, 0, 20);
    #1;
    check("R9", int'(trans_level), 115);
    set_cfg(0, 1, 0, 0, 100, 0, 10);
    #1;
    check("R9", int'(trans_valid), 1);
    set_cfg(1, 1, 0, 0, 100, 0, 10);
    tick(1, "R9");

    // R6, R7, R8: ramps across both thresholds (upper 115, lower 100)
    for (int f = 0; f <= 200; f++) begin
      fill_level = 11'(f);
      tick(1, "HYS");
    end
    for (int f = 200; f >= 0; f--) begin
      fill_level = 11'(f);
      tick(1, "HYS");
    end
    for (int r = 0; r < 6; r++) begin
      fill_level = 11'd115; tick(1, "HYS");
      fill_level = 11'd116; tick(1, "HYS");
      fill_level = 11'd100; tick(1, "HYS");
      fill_level = 11'd99;  tick(1, "HYS");
      fill_level = 11'd108; tick(1, "HYS");
    end

    // R2: disarm while in the low state with a full buffer
    fill_level = 11'd500;
    tick(1, "HYS");
    set_cfg(0, 1, 0, 0, 100, 0, 10);
    tick(1, "R2");
    tick(1, "R2");
    set_cfg(1, 0, 1, 1, 300, 900, 63);
    tick(1, "R2");
    fill_level = 11'd2047;
    tick(1, "R2");
    set_cfg(1, 1, 0, 0, 100, 0, 10);
    fill_level = 11'd110;
    tick(1, "HYS");
    tick(1, "HYS");
    fill_level = 11'd300;
    tick(1, "HYS");
    tick(1, "HYS");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule